// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This controller sits between the CPU-side flash control registers and the flash array sequencer. It holds a small set of control bits written through a synchronous register port and decides, every cycle, whether a program or erase operation may run, which blocks an erase may touch, and whether a verify mode is open. Three independent protection sources gate program and erase: a software write-enable bit, a per-block erase-enable mask, and a RAM-emulation bit.

A sticky error lockout guards against runaway software. Certain CPU-side events that occur while program or erase is running set the error flag. The same events are harmless at any other time. The flag aborts the running operation and keeps program and erase shut until reset or hardware standby. The register contents are preserved, so verify modes can still be opened for diagnosis.

Register writes use `wr_sel`: 0 selects the control register, 1 the request register, 2 the erase mask, and 3 is unused. Control register bits: bit 0 is write enable, bit 1 is RAM emulation. Request register bits: bit 0 is program, bit 1 is erase, bit 2 is program-verify, bit 3 is erase-verify. The erase mask takes `wr_data[NUM_BLOCKS-1:0]`, where bit i enables block i.

Top module: `flash_guard`

## Requirements
- R1: While the write-enable bit (control bit 0) is 0, `prog_act`, `erase_act` and every `blk_erase` bit stay 0, whatever the request bits hold.
- R2: While erasing, `blk_erase[i]` is 1 exactly for those blocks whose mask bit i is 1. A block whose mask bit is 0 never sees its strobe.
- R3: When the whole erase mask is zero, `erase_act` stays 0.
- R4: While the RAM-emulation bit (control bit 1) is 1, `prog_act` and `erase_act` stay 0.
- R5: If the program and erase request bits are both 1, neither `prog_act` nor `erase_act` is asserted.
- R6: A flash read, exception entry, sleep entry or bus loss seen at a clock edge while `prog_act` or `erase_act` is 1 sets `err_flag` after that edge. In the same cycle, `prog_act`, `erase_act` and all strobes drop to 0.
- R7: The same events seen while neither `prog_act` nor `erase_act` is 1, including in verify mode, leave `err_flag` at 0.
- R8: While `err_flag` is 1, rewriting the program or erase request does not raise `prog_act` or `erase_act`. The retained write-enable bit still lets a verify request open its verify mode.
- R9: No register write clears `err_flag`. Only reset or hardware standby clears it.
- R10: A low `rst_n` or a high `hw_stby` at a clock edge clears all control bits, request bits, the mask and `err_flag`, so every output is 0 after that edge.
- R11: `pv_act` is 1 when write enable is 1 and program-verify is the only request bit set. `ev_act` is 1 when write enable is 1 and erase-verify is the only request bit set. Neither verify mode depends on the RAM-emulation bit or the error flag.
- R12: A register write takes effect at the clock edge where `wr_en` is 1, and outputs reflect it after that edge. A write with `wr_sel` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_stby | input | 1 | Hardware standby entry, clears like reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 request, 2 mask, 3 unused |
| wr_data | input | DATA_W | Write data |
| ev_flash_rd | input | 1 | CPU read of the flash array (including vector or instruction fetch) |
| ev_exc | input | 1 | Exception handling entry other than reset |
| ev_sleep | input | 1 | Sleep or software-standby entry |
| ev_bus_loss | input | 1 | CPU lost the bus |
| prog_act | output | 1 | Program mode active |
| erase_act | output | 1 | Erase mode active |
| blk_erase | output | NUM_BLOCKS | Per-block erase strobes |
| pv_act | output | 1 | Program-verify mode active |
| ev_act | output | 1 | Erase-verify mode active |
| err_flag | output | 1 | Sticky error lockout |

## Verification
The bench builds the controller with NUM_BLOCKS = 6, which makes the write data six bits wide. With so few blocks, random mask writes often land on the all-zero mask and the all-ones mask, and they hit each single-block pattern. As a result, the empty-mask protection and the per-block strobe gating are both exercised without steering. Random event bursts then fall across idle, verify, program and erase states. These bursts are mixed with directed passes that fire each of the four error events once during an active mode.

// File: rtl/flash_guard_pkg.sv
// Package: shared types for the flash program/erase protection controller.
// Assumes nothing beyond a single clock domain.
package flash_guard_pkg;

    // Register select codes of the synchronous write port.
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_REQ  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } fg_sel_e;

    // Field positions inside the control and request registers.
    localparam int CTRL_WEN_BIT  = 0;
    localparam int CTRL_EMUL_BIT = 1;
    localparam int REQ_PROG_BIT  = 0;
    localparam int REQ_ERASE_BIT = 1;
    localparam int REQ_PV_BIT    = 2;
    localparam int REQ_EV_BIT    = 3;

    // Number of CPU-side error event inputs.
    localparam int NUM_EVENTS = 4;

    // Control and request bits held by the register block.
    typedef struct packed {
        logic wen;
        logic emul;
        logic preq;
        logic ereq;
        logic pvreq;
        logic evreq;
    } fg_ctrl_t;

endpackage

// File: rtl/fg_ctrl_regs.sv
// Module: fg_ctrl_regs
// Holds the control bits, request bits and erase mask written through a
// simple synchronous port. Assumes DATA_W >= 4 and DATA_W >= NUM_BLOCKS.
// Clears on synchronous active-low reset or hardware standby.
module fg_ctrl_regs
    import flash_guard_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int DATA_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    output fg_ctrl_t              ctrl,
    output logic [NUM_BLOCKS-1:0] mask
);

    logic clr;
    assign clr = !rst_n || hw_stby;

    // Control register: write enable and RAM emulation.
    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl.wen  <= 1'b0;
            ctrl.emul <= 1'b0;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            ctrl.wen  <= wr_data[CTRL_WEN_BIT];
            ctrl.emul <= wr_data[CTRL_EMUL_BIT];
        end
    end

    // Request register: program, erase and the two verify requests.
    always_ff @(posedge clk) begin
        if (clr) begin
            ctrl.preq  <= 1'b0;
            ctrl.ereq  <= 1'b0;
            ctrl.pvreq <= 1'b0;
            ctrl.evreq <= 1'b0;
        end else if (wr_en && wr_sel == SEL_REQ) begin
            ctrl.preq  <= wr_data[REQ_PROG_BIT];
            ctrl.ereq  <= wr_data[REQ_ERASE_BIT];
            ctrl.pvreq <= wr_data[REQ_PV_BIT];
            ctrl.evreq <= wr_data[REQ_EV_BIT];
        end
    end

    // Erase-enable mask: one bit per block.
    always_ff @(posedge clk) begin
        if (clr) begin
            mask <= '0;
        end else if (wr_en && wr_sel == SEL_MASK) begin
            mask <= wr_data[NUM_BLOCKS-1:0];
        end
    end

    // R10: a clear leaves every register at zero.
    a_r10_regs_clear: assert property (@(posedge clk)
        clr |=> (ctrl == '0 && mask == '0));

    // R12: an unused select leaves the registers unchanged.
    a_r12_sel_none: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE && !hw_stby) |=> ($stable(ctrl) && $stable(mask)));

endmodule

// File: rtl/fg_mode_decode.sv
// Module: fg_mode_decode
// Merges the three protection sources and the error lockout into program,
// erase and verify mode enables, and fans erase out to per-block strobes.
// Purely combinational; clk and rst_n serve the assertions only.
module fg_mode_decode
    import flash_guard_pkg::*;
#(
    parameter int NUM_BLOCKS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  fg_ctrl_t              ctrl,
    input  logic [NUM_BLOCKS-1:0] mask,
    input  logic                  err,
    output logic                  prog_act,
    output logic                  erase_act,
    output logic [NUM_BLOCKS-1:0] blk_erase,
    output logic                  pv_act,
    output logic                  ev_act
);

    logic sw_open;     // write enable set and emulation off
    logic one_pe;      // exactly one of program/erase requested
    logic any_block;   // at least one block erase-enabled
    logic no_pe_req;   // neither program nor erase requested

    // Protection merge: every source must allow the operation.
    always_comb begin
        sw_open   = ctrl.wen && !ctrl.emul;
        one_pe    = ctrl.preq ^ ctrl.ereq;
        any_block = |mask;
        no_pe_req = !ctrl.preq && !ctrl.ereq;
    end

    // Mode enables for program and erase, shut by the lockout.
    always_comb begin
        prog_act  = sw_open && one_pe && ctrl.preq && !err;
        erase_act = sw_open && one_pe && ctrl.ereq && any_block && !err;
    end

    // Verify modes: need write enable and a lone verify request.
    always_comb begin
        pv_act = ctrl.wen && no_pe_req && ctrl.pvreq && !ctrl.evreq;
        ev_act = ctrl.wen && no_pe_req && ctrl.evreq && !ctrl.pvreq;
    end

    // Per-block erase strobes.
    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        assign blk_erase[b] = erase_act && mask[b];

        // R2: a disabled block never receives a strobe.
        a_r2_block_gated: assert property (@(posedge clk) disable iff (!rst_n)
            !mask[b] |-> !blk_erase[b]);
    end

    // R1: write enable low keeps program and erase off.
    a_r1_wen_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.wen |-> (!prog_act && !erase_act));

    // R3: an empty mask keeps erase off.
    a_r3_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !erase_act);

    // R4: emulation keeps program and erase off.
    a_r4_emul_off: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.emul |-> (!prog_act && !erase_act));

    // R5: program and erase never run together.
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_act && erase_act));

    // R8: the lockout shuts program and erase.
    a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!prog_act && !erase_act && blk_erase == '0));

    // R11: at most one verify mode at a time.
    a_r11_verify_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pv_act, ev_act}));

endmodule

// File: rtl/fg_error_lock.sv
// Module: fg_error_lock
// Sticky error lockout. Any CPU-side event during program or erase sets it;
// events at other times are ignored. Only reset or hardware standby clear it.
module fg_error_lock
    import flash_guard_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  pe_active,
    output logic                  err
);

    logic hit;
    assign hit = (|events) && pe_active;

    // Error flag: set on a hit, held until reset or standby.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_stby) begin
            err <= 1'b0;
        end else if (hit) begin
            err <= 1'b1;
        end
    end

    // R6: an event during program or erase sets the flag.
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((|events) && pe_active && !hw_stby) |=> err);

    // R7: events while idle or verifying leave a clear flag clear.
    a_r7_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!err && !pe_active) |=> !err);

    // R9: the flag holds until reset or standby.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !hw_stby) |=> err);

    // R10: standby clears the flag.
    a_r10_stby_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> !err);

endmodule

// File: rtl/flash_guard.sv
// Module: flash_guard (top)
// Flash program/erase protection controller: register block, mode decode
// and sticky error lockout. Assumes synchronous active-low reset and a
// write data width covering both the request register and the erase mask.
module flash_guard
    import flash_guard_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int DATA_W     = (NUM_BLOCKS < 4) ? 4 : NUM_BLOCKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hw_stby,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  ev_flash_rd,
    input  logic                  ev_exc,
    input  logic                  ev_sleep,
    input  logic                  ev_bus_loss,
    output logic                  prog_act,
    output logic                  erase_act,
    output logic [NUM_BLOCKS-1:0] blk_erase,
    output logic                  pv_act,
    output logic                  ev_act,
    output logic                  err_flag
);

    fg_ctrl_t              ctrl;
    logic [NUM_BLOCKS-1:0] mask;
    logic [NUM_EVENTS-1:0] events;
    logic                  err;

    assign events   = {ev_bus_loss, ev_sleep, ev_exc, ev_flash_rd};
    assign err_flag = err;

    fg_ctrl_regs #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .DATA_W     (DATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .mask    (mask)
    );

    fg_mode_decode #(
        .NUM_BLOCKS (NUM_BLOCKS)
    ) decode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .mask      (mask),
        .err       (err),
        .prog_act  (prog_act),
        .erase_act (erase_act),
        .blk_erase (blk_erase),
        .pv_act    (pv_act),
        .ev_act    (ev_act)
    );

    fg_error_lock lock_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_stby   (hw_stby),
        .events    (events),
        .pe_active (prog_act || erase_act),
        .err       (err)
    );

    // R6: the abort shows in the same cycle as the flag.
    a_r6_abort_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (!prog_act && !erase_act && blk_erase == '0));

    // R10: reset leaves every output at zero.
    a_r10_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (!prog_act && !erase_act && !pv_act && !ev_act && !err_flag));

endmodule

// File: tb/flash_guard_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic against a
// requirement-level model held in bench variables.
module flash_guard_tb_top;

    localparam int NB = 6;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_stby = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          ev_flash_rd = 1'b0;
    logic          ev_exc = 1'b0;
    logic          ev_sleep = 1'b0;
    logic          ev_bus_loss = 1'b0;
    logic          prog_act, erase_act, pv_act, ev_act, err_flag;
    logic [NB-1:0] blk_erase;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state.
    logic m_wen, m_emul, m_p, m_e, m_pv, m_ev, m_err;
    logic [NB-1:0] m_mask;

    always #2 clk = ~clk;

    flash_guard #(.NUM_BLOCKS(NB), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ev_flash_rd(ev_flash_rd), .ev_exc(ev_exc), .ev_sleep(ev_sleep),
        .ev_bus_loss(ev_bus_loss),
        .prog_act(prog_act), .erase_act(erase_act), .blk_erase(blk_erase),
        .pv_act(pv_act), .ev_act(ev_act), .err_flag(err_flag)
    );

    function automatic logic exp_prog();
        return m_wen && !m_emul && m_p && !m_e && !m_err;
    endfunction

    function automatic logic exp_erase();
        return m_wen && !m_emul && m_e && !m_p && (m_mask != '0) && !m_err;
    endfunction

    function automatic logic [NB+4:0] exp_vec();
        logic pv, ev;
        pv = m_wen && !m_p && !m_e && m_pv && !m_ev;
        ev = m_wen && !m_p && !m_e && m_ev && !m_pv;
        return {exp_prog(), exp_erase(), exp_erase() ? m_mask : {NB{1'b0}}, pv, ev, m_err};
    endfunction

    function automatic string classify();
        if (m_err) return "R8";
        if (!m_wen) return "R1";
        if (m_emul) return "R4";
        if (m_p && m_e) return "R5";
        if (m_e && m_mask == '0) return "R3";
        if (m_e) return "R2";
        return "R11";
    endfunction

    task automatic check(input string tag);
        logic [NB+4:0] act, exp;
        act = {prog_act, erase_act, blk_erase, pv_act, ev_act, err_flag};
        exp = exp_vec();
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a negedge, update the model at the
    // edge, and return at the next negedge with outputs settled.
    task automatic step(input logic we, input logic [1:0] sel,
                        input logic [DW-1:0] d, input logic [3:0] evs,
                        input logic rn, input logic st);
        logic hit;
        wr_en = we; wr_sel = sel; wr_data = d;
        {ev_bus_loss, ev_sleep, ev_exc, ev_flash_rd} = evs;
        rst_n = rn; hw_stby = st;
        @(posedge clk);
        hit = (evs != 4'd0) && (exp_prog() || exp_erase());
        if (!rn || st) begin
            {m_wen, m_emul, m_p, m_e, m_pv, m_ev, m_err} = '0;
            m_mask = '0;
        end else begin
            if (hit) m_err = 1'b1;
            if (we && sel == 2'd0) begin
                m_wen = d[0]; m_emul = d[1];
            end else if (we && sel == 2'd1) begin
                m_p = d[0]; m_e = d[1]; m_pv = d[2]; m_ev = d[3];
            end else if (we && sel == 2'd2) begin
                m_mask = d[NB-1:0];
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        {ev_bus_loss, ev_sleep, ev_exc, ev_flash_rd} = 4'd0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        step(1'b1, sel, d, 4'd0, 1'b1, 1'b0);
    endtask

    task automatic idle(input logic [3:0] evs);
        step(1'b0, 2'd0, '0, evs, 1'b1, 1'b0);
    endtask

    task automatic do_reset();
        step(1'b0, 2'd0, '0, 4'd0, 1'b0, 1'b0);
    endtask

    task automatic expect_bit(input string tag, input logic a, input logic e);
        n_checks++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, a, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        {m_wen, m_emul, m_p, m_e, m_pv, m_ev, m_err} = '0;
        m_mask = '0;
        @(negedge clk);
        do_reset(); do_reset();
        check("R10 reset state");

        // R12 + R1: program opens only after write enable is written.
        wr(2'd1, 6'b000001);
        check("R1 request with wen=0");
        wr(2'd0, 6'b000001);
        check("R12 control write");
        expect_bit("R1 prog open", prog_act, 1'b1);

        // R12: unused select changes nothing.
        wr(2'd3, 6'b111111);
        check("R12 sel 3 ignored");

        // R4: emulation shuts program.
        wr(2'd0, 6'b000011);
        check("R4 emulation");
        wr(2'd0, 6'b000001);

        // R2/R3: erase with mask patterns.
        wr(2'd2, 6'b101001);
        wr(2'd1, 6'b000010);
        check("R2 erase strobes");
        expect_bit("R2 block 1 gated", blk_erase[1], 1'b0);
        wr(2'd2, 6'b000000);
        check("R3 empty mask");
        expect_bit("R3 erase_act", erase_act, 1'b0);
        wr(2'd2, 6'b111111);

        // R5: both requests.
        wr(2'd1, 6'b000011);
        check("R5 both requests");

        // R11: verify modes.
        wr(2'd1, 6'b000100);
        check("R11 program-verify");
        expect_bit("R11 pv_act", pv_act, 1'b1);
        wr(2'd1, 6'b001100);
        check("R11 both verify");

        // R7: events in verify and idle are ignored.
        wr(2'd1, 6'b001000);
        idle(4'b1111);
        check("R7 events in verify");
        expect_bit("R7 err in verify", err_flag, 1'b0);
        wr(2'd1, 6'b000000);
        idle(4'b1111);
        expect_bit("R7 err idle", err_flag, 1'b0);

        // R6: each event kind during program or erase.
        for (int k = 0; k < 4; k++) begin
            do_reset();
            wr(2'd0, 6'b000001);
            wr(2'd2, 6'b010110);
            wr(2'd1, (k % 2 == 0) ? 6'b000001 : 6'b000010);
            idle(4'b0001 << k);
            check("R6 event sets error");
            expect_bit("R6 err_flag", err_flag, 1'b1);
            expect_bit("R6 abort", prog_act | erase_act, 1'b0);
            // R8: rewrite of request does not re-enter; verify opens.
            wr(2'd1, 6'b000001);
            expect_bit("R8 no re-entry prog", prog_act, 1'b0);
            wr(2'd1, 6'b000010);
            expect_bit("R8 no re-entry erase", erase_act, 1'b0);
            wr(2'd1, 6'b000100);
            expect_bit("R8 verify allowed", pv_act, 1'b1);
            // R9: writes do not clear.
            wr(2'd0, 6'b000000);
            wr(2'd2, 6'b000000);
            expect_bit("R9 writes keep error", err_flag, 1'b1);
        end

        // R10/R9: standby clears.
        wr(2'd0, 6'b000001);
        step(1'b0, 2'd0, '0, 4'd0, 1'b1, 1'b1);
        check("R10 standby clear");
        expect_bit("R9 standby clears err", err_flag, 1'b0);

        // Random traffic.
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [1:0] sel;
            logic [DW-1:0] d;
            logic [3:0] evs;
            logic rn, st;
            string tag;
            we  = ($urandom % 3) != 0;
            sel = 2'($urandom % 4);
            d   = DW'($urandom);
            if (sel == 2'd0 && ($urandom % 4) != 0) d[1] = 1'b0;
            evs = (($urandom % 6) == 0) ? 4'($urandom) : 4'd0;
            rn  = ($urandom % 200) != 0;
            st  = ($urandom % 250) == 0;
            step(we, sel, d, evs, rn, st);
            tag = classify();
            if (evs != 4'd0) tag = m_err ? "R6" : "R7";
            if (!rn || st) tag = "R10";
            check(tag);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule